// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Staged Squash

This block keeps in-flight instructions in program order for several hardware threads at once. Each thread owns a private circular queue. Every entry carries a global sequence number, a data payload, a ready-to-commit mark and a squashed mark. New entries are written at the tail of the issuing thread's queue. Execution logic marks an entry complete by naming its thread and slot. The commit stage retires entries from each thread's head.

A squash request names a thread and a boundary sequence number. The thread then walks backward from its tail, handling at most `SQW` entries per cycle. Every entry younger than the boundary is tagged as squashed and also as ready, so it drains out through ordinary retirement rather than being deleted at once. The block also reports whether any active thread can commit, and it reports the oldest head and the youngest tail over all active threads. It keeps two event counters, one for head lookups and one for writes.

Allocation is a valid/ready stream. An entry is accepted on a clock edge where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` depends only on `alloc_tid` and on the block's state, never on `alloc_valid`. A producer facing a low `alloc_ready` holds its request or withdraws it, and nothing is written. Completion marks, retire requests and squash requests are plain control pins with no back-pressure.

Top module: `mt_rob`

## Requirements
- R1: An accepted allocation writes its sequence number and payload at the tail of thread `alloc_tid`. `alloc_slot` gives the slot it lands in. `alloc_ready` is low when that thread holds `DEPTH` entries, and a request offered while `alloc_ready` is low changes nothing.
- R2: A retire request removes the thread's head entry only when that thread's `head_ready` is high. A request made while the head is not ready changes nothing.
- R3: `head_ready[t]` is high exactly when thread t is non-empty and its head entry is marked ready. `can_commit` is the OR of `head_ready` over the threads whose `thread_active` bit is set.
- R4: A squash request on an empty thread is ignored, and `squash_done` for that thread stays high.
- R5: On the edge that accepts a squash request, the thread records the boundary and drops its `squash_done`. On each later edge it scans up to `SQW` entries, going from its tail toward its head. Every scanned entry whose sequence number is greater than the boundary becomes both squashed and ready.
- R6: The scan stops on the edge where it marks the head entry, or where it meets an entry whose sequence number is at or below the boundary. `squash_done` is high again after that edge.
- R7: While thread t is squashing, and in the cycle its squash request is presented, allocation to t is refused and retirement from t is held off.
- R8: `oldest_valid`, `oldest_tid` and `oldest_seq` give the non-empty active thread whose head has the lowest sequence number, with the lower thread id winning a tie. `oldest_valid` is low when no active thread holds an entry.
- R9: `youngest_*` gives the non-empty active thread whose tail has the highest sequence number. Squashed entries count toward this until they retire.
- R10: `rd_events` adds one for each retire request presented. `wr_events` adds one for each accepted allocation, each accepted retirement, and each cycle a thread spends scanning.
- R11: After reset every thread is empty, `squash_done` is all ones, `can_commit` and `oldest_valid` are low, and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thread_active | input | NTHR | Threads that take part in commit and oldest/youngest selection |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Allocation can be accepted for alloc_tid |
| alloc_tid | input | TW | Thread of the allocation |
| alloc_seq | input | SEQW | Sequence number of the new entry |
| alloc_data | input | DW | Payload of the new entry |
| alloc_slot | output | AW | Slot the allocation will occupy |
| mark_valid | input | 1 | Completion mark strobe |
| mark_tid | input | TW | Thread of the completed entry |
| mark_slot | input | AW | Slot of the completed entry |
| retire_req | input | NTHR | Per-thread retire request |
| squash_req | input | NTHR | Per-thread squash request |
| squash_bnd | input | NTHR*SEQW | Per-thread boundary sequence numbers |
| head_valid | output | NTHR | Thread holds at least one entry |
| head_ready | output | NTHR | Thread head is ready to commit |
| head_squashed | output | NTHR | Thread head carries the squashed mark |
| head_seq | output | NTHR*SEQW | Sequence number of each thread head |
| head_data | output | NTHR*DW | Payload of each thread head |
| can_commit | output | 1 | Some active thread has a ready head |
| squash_done | output | NTHR | Thread is not squashing |
| oldest_valid | output | 1 | An active thread holds an entry |
| oldest_tid | output | TW | Thread of the oldest head |
| oldest_seq | output | SEQW | Sequence number of the oldest head |
| youngest_valid | output | 1 | An active thread holds an entry |
| youngest_tid | output | TW | Thread of the youngest tail |
| youngest_seq | output | SEQW | Sequence number of the youngest tail |
| rd_events | output | CNTW | Head lookup counter |
| wr_events | output | CNTW | Write event counter |

## Verification
Allocation, marks and retirement show up on the head, commit and oldest/youngest outputs right after the edge that samples them. `alloc_ready` and `alloc_slot` are combinational and are read before that edge. A squash takes one edge to start and then one edge per group of `SQW` entries, so `squash_done` is checked after each of these edges. The bench drives its inputs one time unit after a rising edge, waits for the next edge plus one unit, and then compares. Every sample therefore reflects exactly the edges that have been counted.

// File: rtl/rob_pkg.sv
package rob_pkg;
  function automatic logic seq_before(input logic [63:0] a, input logic [63:0] b);
    return a < b;
  endfunction
endpackage

// File: rtl/rob_thread_q.sv
module rob_thread_q #(
  parameter int DEPTH = 8,
  parameter int SEQW  = 16,
  parameter int DW    = 8,
  parameter int SQW   = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_en,
  input  logic [SEQW-1:0] alloc_seq,
  input  logic [DW-1:0]   alloc_data,
  input  logic            mark_en,
  input  logic [AW-1:0]   mark_slot,
  input  logic            retire_en,
  input  logic            sq_req,
  input  logic [SEQW-1:0] sq_bnd,
  output logic            can_alloc,
  output logic            busy,
  output logic [CW-1:0]   occ,
  output logic [AW-1:0]   tail_slot,
  output logic [SEQW-1:0] hd_seq,
  output logic [DW-1:0]   hd_data,
  output logic            hd_rdy,
  output logic            hd_sqd,
  output logic [SEQW-1:0] tl_seq,
  output logic            alloc_ok,
  output logic            retire_ok
);
  logic [SEQW-1:0] seq_q [DEPTH];
  logic [DW-1:0]   dat_q [DEPTH];
  logic [DEPTH-1:0] rdy_q, sqd_q, sq_mark;
  logic [AW-1:0]   hd_q, wr_q, scan_q, scan_nx, p;
  logic [CW-1:0]   cnt_q;
  logic [SEQW-1:0] bnd_q;
  logic            busy_q, fin, go, hold, sq_start;

  assign hold      = busy_q | sq_req;
  assign can_alloc = (cnt_q != CW'(DEPTH)) && !hold;
  assign alloc_ok  = alloc_en && can_alloc;
  assign hd_rdy    = (cnt_q != '0) && rdy_q[hd_q];
  assign hd_sqd    = (cnt_q != '0) && sqd_q[hd_q];
  assign retire_ok = retire_en && hd_rdy && !hold;
  assign sq_start  = sq_req && !busy_q && (cnt_q != '0);
  assign hd_seq    = seq_q[hd_q];
  assign hd_data   = dat_q[hd_q];
  assign tl_seq    = seq_q[wr_q - 1'b1];
  assign tail_slot = wr_q;
  assign occ       = cnt_q;
  assign busy      = busy_q;

  // backward scan: up to SQW entries per cycle, youngest first
  always_comb begin
    p       = scan_q;
    go      = busy_q;
    fin     = 1'b0;
    sq_mark = '0;
    for (int k = 0; k < SQW; k++) begin
      if (go) begin
        if (seq_q[p] > bnd_q) begin
          sq_mark[p] = 1'b1;
          if (p == hd_q) begin
            fin = 1'b1;
            go  = 1'b0;
          end else begin
            p = p - 1'b1;
          end
        end else begin
          fin = 1'b1;
          go  = 1'b0;
        end
      end
    end
    scan_nx = p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        seq_q[i] <= '0;
        dat_q[i] <= '0;
      end
      rdy_q  <= '0;
      sqd_q  <= '0;
      hd_q   <= '0;
      wr_q   <= '0;
      scan_q <= '0;
      cnt_q  <= '0;
      bnd_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (mark_en) rdy_q[mark_slot] <= 1'b1;
      rdy_q <= (mark_en ? (rdy_q | (DEPTH'(1) << mark_slot)) : rdy_q) | sq_mark;
      sqd_q <= sqd_q | sq_mark;
      if (alloc_ok) begin
        seq_q[wr_q] <= alloc_seq;
        dat_q[wr_q] <= alloc_data;
        rdy_q[wr_q] <= 1'b0;
        sqd_q[wr_q] <= 1'b0;
        wr_q        <= wr_q + 1'b1;
      end
      if (retire_ok) hd_q <= hd_q + 1'b1;
      cnt_q <= cnt_q + CW'(alloc_ok) - CW'(retire_ok);
      if (sq_start) begin
        busy_q <= 1'b1;
        scan_q <= wr_q - 1'b1;
        bnd_q  <= sq_bnd;
      end else if (busy_q) begin
        scan_q <= scan_nx;
        if (fin) busy_q <= 1'b0;
      end
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_retire_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_ok && !alloc_ok) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_empty_squash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_req && !busy_q && cnt_q == '0) |=> !busy_q);
  p_squash_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sq_start |=> busy_q);
  p_scan_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && seq_q[scan_q] > bnd_q) |=> (sqd_q[$past(scan_q)] && rdy_q[$past(scan_q)]));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (!alloc_ok && !retire_ok));
endmodule

// File: rtl/rob_select.sv
module rob_select #(
  parameter int NTHR = 2,
  parameter int SEQW = 16,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic [NTHR-1:0]      act,
  input  logic [NTHR-1:0]      nz,
  input  logic [NTHR*SEQW-1:0] hseq,
  input  logic [NTHR*SEQW-1:0] tseq,
  output logic                 old_v,
  output logic [TW-1:0]        old_tid,
  output logic [SEQW-1:0]      old_seq,
  output logic                 yng_v,
  output logic [TW-1:0]        yng_tid,
  output logic [SEQW-1:0]      yng_seq
);
  import rob_pkg::*;

  always_comb begin
    old_v = 1'b0; old_tid = '0; old_seq = '0;
    yng_v = 1'b0; yng_tid = '0; yng_seq = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (act[t] && nz[t]) begin
        if (!old_v || seq_before(64'(hseq[t*SEQW +: SEQW]), 64'(old_seq))) begin
          old_seq = hseq[t*SEQW +: SEQW];
          old_tid = TW'(t);
        end
        if (!yng_v || seq_before(64'(yng_seq), 64'(tseq[t*SEQW +: SEQW]))) begin
          yng_seq = tseq[t*SEQW +: SEQW];
          yng_tid = TW'(t);
        end
        old_v = 1'b1;
        yng_v = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rob_evcnt.sv
module rob_evcnt #(
  parameter int CNTW = 16,
  parameter int RW   = 2,
  parameter int WW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RW-1:0]   rd_n,
  input  logic [WW-1:0]   wr_n,
  output logic [CNTW-1:0] rd_cnt,
  output logic [CNTW-1:0] wr_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else begin
      rd_cnt <= rd_cnt + CNTW'(rd_n);
      wr_cnt <= wr_cnt + CNTW'(wr_n);
    end
  end

  p_cnt_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n != '0 && wr_cnt != '1) |=> wr_cnt != $past(wr_cnt));
endmodule

// File: rtl/mt_rob.sv
module mt_rob #(
  parameter int NTHR  = 2,
  parameter int DEPTH = 8,
  parameter int SEQW  = 16,
  parameter int DW    = 8,
  parameter int SQW   = 2,
  parameter int CNTW  = 16,
  localparam int TW   = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NTHR-1:0]      thread_active,
  input  logic                 alloc_valid,
  output logic                 alloc_ready,
  input  logic [TW-1:0]        alloc_tid,
  input  logic [SEQW-1:0]      alloc_seq,
  input  logic [DW-1:0]        alloc_data,
  output logic [AW-1:0]        alloc_slot,
  input  logic                 mark_valid,
  input  logic [TW-1:0]        mark_tid,
  input  logic [AW-1:0]        mark_slot,
  input  logic [NTHR-1:0]      retire_req,
  input  logic [NTHR-1:0]      squash_req,
  input  logic [NTHR*SEQW-1:0] squash_bnd,
  output logic [NTHR-1:0]      head_valid,
  output logic [NTHR-1:0]      head_ready,
  output logic [NTHR-1:0]      head_squashed,
  output logic [NTHR*SEQW-1:0] head_seq,
  output logic [NTHR*DW-1:0]   head_data,
  output logic                 can_commit,
  output logic [NTHR-1:0]      squash_done,
  output logic                 oldest_valid,
  output logic [TW-1:0]        oldest_tid,
  output logic [SEQW-1:0]      oldest_seq,
  output logic                 youngest_valid,
  output logic [TW-1:0]        youngest_tid,
  output logic [SEQW-1:0]      youngest_seq,
  output logic [CNTW-1:0]      rd_events,
  output logic [CNTW-1:0]      wr_events
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int RW = $clog2(NTHR + 1);
  localparam int WW = $clog2(2 * NTHR + 2);

  logic [NTHR-1:0]      can_alloc, busy, alloc_ok, retire_ok;
  logic [NTHR*SEQW-1:0] tail_seq;
  logic [AW-1:0]        tslot [NTHR];
  logic [RW-1:0]        rd_n;
  logic [WW-1:0]        wr_n;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [CW-1:0] occ;
    rob_thread_q #(.DEPTH(DEPTH), .SEQW(SEQW), .DW(DW), .SQW(SQW)) i_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (alloc_valid && alloc_tid == TW'(t)),
      .alloc_seq (alloc_seq),
      .alloc_data(alloc_data),
      .mark_en   (mark_valid && mark_tid == TW'(t)),
      .mark_slot (mark_slot),
      .retire_en (retire_req[t]),
      .sq_req    (squash_req[t]),
      .sq_bnd    (squash_bnd[t*SEQW +: SEQW]),
      .can_alloc (can_alloc[t]),
      .busy      (busy[t]),
      .occ       (occ),
      .tail_slot (tslot[t]),
      .hd_seq    (head_seq[t*SEQW +: SEQW]),
      .hd_data   (head_data[t*DW +: DW]),
      .hd_rdy    (head_ready[t]),
      .hd_sqd    (head_squashed[t]),
      .tl_seq    (tail_seq[t*SEQW +: SEQW]),
      .alloc_ok  (alloc_ok[t]),
      .retire_ok (retire_ok[t])
    );
    assign head_valid[t] = (occ != '0);
  end

  assign alloc_ready = can_alloc[alloc_tid];
  assign alloc_slot  = tslot[alloc_tid];
  assign can_commit  = |(head_ready & thread_active);
  assign squash_done = ~busy;

  rob_select #(.NTHR(NTHR), .SEQW(SEQW)) i_sel (
    .act    (thread_active),
    .nz     (head_valid),
    .hseq   (head_seq),
    .tseq   (tail_seq),
    .old_v  (oldest_valid),
    .old_tid(oldest_tid),
    .old_seq(oldest_seq),
    .yng_v  (youngest_valid),
    .yng_tid(youngest_tid),
    .yng_seq(youngest_seq)
  );

  assign rd_n = RW'($countones(retire_req));
  assign wr_n = WW'($countones(alloc_ok)) + WW'($countones(retire_ok)) + WW'($countones(busy));

  rob_evcnt #(.CNTW(CNTW), .RW(RW), .WW(WW)) i_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .rd_cnt(rd_events),
    .wr_cnt(wr_events)
  );

  p_commit_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    can_commit |-> |(head_valid & thread_active));
  p_sel_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oldest_valid == youngest_valid);
  p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oldest_valid |-> (oldest_seq <= youngest_seq || oldest_tid != youngest_tid));
  p_one_alloc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_ok));
endmodule

// File: tb/test_mt_rob.sv
`timescale 1ns/100ps
module test_mt_rob;
  localparam int NTHR = 2, DEPTH = 4, SEQW = 8, DW = 8, SQW = 2, CNTW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] thread_active;
  logic alloc_valid, alloc_ready, mark_valid;
  logic [0:0] alloc_tid, mark_tid, oldest_tid, youngest_tid;
  logic [7:0] alloc_seq, alloc_data, oldest_seq, youngest_seq;
  logic [1:0] alloc_slot, mark_slot;
  logic [1:0] retire_req, squash_req, head_valid, head_ready, head_squashed, squash_done;
  logic [15:0] squash_bnd, head_seq, head_data;
  logic can_commit, oldest_valid, youngest_valid;
  logic [15:0] rd_events, wr_events;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mt_rob #(.NTHR(NTHR), .DEPTH(DEPTH), .SEQW(SEQW), .DW(DW), .SQW(SQW), .CNTW(CNTW)) i_mt_rob (
    .clk(clk), .rst_n(rst_n), .thread_active(thread_active),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tid(alloc_tid),
    .alloc_seq(alloc_seq), .alloc_data(alloc_data), .alloc_slot(alloc_slot),
    .mark_valid(mark_valid), .mark_tid(mark_tid), .mark_slot(mark_slot),
    .retire_req(retire_req), .squash_req(squash_req), .squash_bnd(squash_bnd),
    .head_valid(head_valid), .head_ready(head_ready), .head_squashed(head_squashed),
    .head_seq(head_seq), .head_data(head_data), .can_commit(can_commit),
    .squash_done(squash_done), .oldest_valid(oldest_valid), .oldest_tid(oldest_tid),
    .oldest_seq(oldest_seq), .youngest_valid(youngest_valid), .youngest_tid(youngest_tid),
    .youngest_seq(youngest_seq), .rd_events(rd_events), .wr_events(wr_events));

  // op(2) tid(1) arg(8) cc(1) old(8) young(8); op 0 alloc, 1 mark, 2 retire
  localparam int NV = 10;
  localparam logic [NV-1:0][27:0] VEC = {
    {2'd0, 1'b0, 8'd10, 1'b0, 8'd10, 8'd10},
    {2'd0, 1'b1, 8'd11, 1'b0, 8'd10, 8'd11},
    {2'd0, 1'b0, 8'd12, 1'b0, 8'd10, 8'd12},
    {2'd1, 1'b1, 8'd0,  1'b1, 8'd10, 8'd12},
    {2'd2, 1'b1, 8'd0,  1'b0, 8'd10, 8'd12},
    {2'd1, 1'b0, 8'd0,  1'b1, 8'd10, 8'd12},
    {2'd2, 1'b0, 8'd0,  1'b0, 8'd12, 8'd12},
    {2'd0, 1'b1, 8'd13, 1'b0, 8'd12, 8'd13},
    {2'd1, 1'b1, 8'd1,  1'b1, 8'd12, 8'd13},
    {2'd2, 1'b1, 8'd0,  1'b0, 8'd12, 8'd12}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_tid = 0; alloc_seq = 0; alloc_data = 0;
    mark_valid = 0; mark_tid = 0; mark_slot = 0;
    retire_req = 0; squash_req = 0; squash_bnd = 0;
  endtask

  task automatic do_reset();
    idle(); thread_active = 2'b11; rst_n = 0;
    tick(); tick(); rst_n = 1; #1;
  endtask

  task automatic alloc(input logic t, input logic [7:0] s);
    alloc_valid = 1; alloc_tid = t; alloc_seq = s; alloc_data = s + 8'd100;
    tick(); idle();
  endtask

  task automatic mark(input logic t, input logic [1:0] sl);
    mark_valid = 1; mark_tid = t; mark_slot = sl; tick(); idle();
  endtask

  task automatic retire(input logic t);
    retire_req[t] = 1'b1; tick(); idle();
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    chk("R11 can_commit", int'(can_commit), 0);
    chk("R11 oldest_valid", int'(oldest_valid), 0);
    chk("R11 squash_done", int'(squash_done), 3);
    chk("R11 head_valid", int'(head_valid), 0);
    chk("R11 wr_events", int'(wr_events), 0);
    chk("R1 alloc_ready empty", int'(alloc_ready), 1);

    // vector walk: R1 R2 R3 R8 R9
    for (int i = NV - 1; i >= 0; i--) begin
      logic [27:0] v;
      v = VEC[i];
      case (v[27:26])
        2'd0: alloc(v[25], v[24:17]);
        2'd1: mark(v[25], v[18:17]);
        default: retire(v[25]);
      endcase
      chk("R3 can_commit vec", int'(can_commit), int'(v[16]));
      chk("R8 oldest_seq vec", int'(oldest_seq), int'(v[15:8]));
      chk("R9 youngest_seq vec", int'(youngest_seq), int'(v[7:0]));
    end
    chk("R10 rd_events", int'(rd_events), 3);
    chk("R10 wr_events", int'(wr_events), 7);

    // R3 and R8: inactive thread excluded
    do_reset();
    alloc(1, 8'd5); mark(1, 2'd0);
    thread_active = 2'b01; #1;
    chk("R3 inactive no commit", int'(can_commit), 0);
    chk("R8 no active entries", int'(oldest_valid), 0);
    thread_active = 2'b11; #1;
    chk("R3 active commit", int'(can_commit), 1);
    chk("R8 oldest tid", int'(oldest_tid), 1);

    // R2: not-ready retire ignored; R1: full refuses
    do_reset();
    alloc(0, 8'd30);
    retire(0);
    chk("R2 unready head kept", int'(head_seq[7:0]), 30);
    chk("R2 head still valid", int'(head_valid[0]), 1);
    alloc_tid = 0; #1;
    chk("R1 alloc_slot", int'(alloc_slot), 1);
    alloc(0, 8'd31); alloc(0, 8'd32); alloc(0, 8'd33);
    alloc_tid = 0; #1;
    chk("R1 full not ready", int'(alloc_ready), 0);
    alloc(0, 8'd99);
    chk("R1 full alloc ignored", int'(youngest_seq), 33);
    alloc(1, 8'd34);

    // R5 R6 R7: squash t0 at boundary 30
    squash_req[0] = 1; squash_bnd[7:0] = 8'd30; mark_valid = 1; mark_tid = 0; mark_slot = 0;
    tick(); idle();
    chk("R5 done drops", int'(squash_done[0]), 0);
    retire_req[0] = 1; tick();
    chk("R6 still scanning", int'(squash_done[0]), 0);
    tick(); idle();
    chk("R6 stops at boundary", int'(squash_done[0]), 1);
    chk("R7 retire held", int'(head_seq[7:0]), 30);
    chk("R6 boundary entry unsquashed", int'(head_squashed[0]), 0);
    retire(0);
    chk("R5 squashed head seq", int'(head_seq[7:0]), 31);
    chk("R5 squashed mark", int'(head_squashed[0]), 1);
    chk("R5 squashed ready", int'(head_ready[0]), 1);

    // R6 stop at head, R7 alloc refused with request
    squash_req[1] = 1; squash_bnd[15:8] = 8'd0; alloc_valid = 1; alloc_tid = 1; alloc_seq = 8'd40; #1;
    chk("R7 alloc refused on request", int'(alloc_ready), 0);
    tick(); idle();
    chk("R5 t1 scanning", int'(squash_done[1]), 0);
    tick();
    chk("R6 stops at head", int'(squash_done[1]), 1);
    chk("R5 t1 head squashed", int'(head_squashed[1]), 1);
    chk("R9 squashed tail kept", int'(youngest_seq), 34);

    // R4 empty squash ignored
    do_reset();
    squash_req[1] = 1; tick(); idle();
    chk("R4 empty squash ignored", int'(squash_done[1]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule